// File: doc/BRIEF.md
# Flash Command Decoder with Status Register

This block sits on the command side of a flash memory. It watches write cycles on the command bus and decodes a small set of command codes. It runs a two-write block erase handshake and keeps an 8-bit status byte. It also chooses whether a read returns array contents or that status byte. The array is not part of the block. In array mode a read returns a fixed placeholder byte.

An erase is started with a setup code followed by a confirm code. The block address is taken from the confirm write. A cycle counter then holds the device busy for a parameterised time, standing in for the real erase. A broken handshake is reported by setting two error bits together. A low programming voltage at confirm time is reported in its own bit, and no erase starts in that case. An input pin can force a chosen erase to fail, so that the failure path can be exercised.

The read data is captured once, when chip enable and output enable both become active. It does not follow the status while a read is held open, so the host must toggle an enable to see a fresh value.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is idle, `busy` is 0, and reads return the placeholder byte `ARRAY_FILL` (array mode).
- R2: A write of 8'h20 while idle enters erase setup and switches reads to status mode. Status bit 7 reads 1 when not busy.
- R3: A write of 8'hD0 in setup, with `vpp_low` = 0, starts an erase. `busy` rises and status bit 7 reads 0 while busy.
- R4: `erase_blk` holds the top `BLK_W` bits of `wr_addr` from the confirm write. `busy` stays high for exactly `ERASE_CYCLES` clock cycles.
- R5: Any code other than 8'hD0 written in setup sets status bits 4 and 5 both to 1, starts no erase, and returns to idle.
- R6: A write of 8'h50 while idle clears status bits 3, 4 and 5 and leaves bit 7 at 1.
- R7: An erase started with `force_fail` = 1 at confirm sets status bit 5 when it ends. Bits 4 and 5 stay set through later erases until they are cleared by 8'h50.
- R8: A confirm write with `vpp_low` = 1 sets status bits 3 and 5 and starts no erase.
- R9: `rd_data` is loaded only in the cycle where (`ce_n`=0 and `oe_n`=0) first becomes true. It holds its value while both stay low.
- R10: Command writes while `busy` is 1 are ignored, including 8'hFF. Reads stay in status mode until 8'hFF is written while idle. A write of 8'hFF while idle selects array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe, one cycle per write |
| wr_data | input | 8 | Command code |
| wr_addr | input | ADDR_W | Write address; its top BLK_W bits select the block |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_low | input | 1 | Programming voltage below limit |
| force_fail | input | 1 | Makes the erase being confirmed fail |
| rd_data | output | 8 | Read data, either status byte or array placeholder |
| busy | output | 1 | Erase in progress |
| erase_blk | output | BLK_W | Block index of the last started erase |

## Verification
The bench builds the block with `ERASE_CYCLES` = 12 and `ARRAY_FILL` = 8'hA5. A busy window of 12 cycles can be counted exactly, and several erases fit into one short run. Because A5 differs from every status value, it separates array mode from status mode at a single read. The bench uses `ADDR_W` = 16 and `BLK_W` = 4, so the block index lands in a visible nibble.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int          ERASE_CYCLES = 1000,
  parameter int          ADDR_W       = 16,
  parameter int          BLK_W        = 4,
  parameter logic [7:0]  ARRAY_FILL   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_low,
  input  logic              force_fail,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic [BLK_W-1:0]  erase_blk
);

  localparam int CW = $clog2(ERASE_CYCLES + 1);
  localparam logic [7:0] C_SETUP = 8'h20;
  localparam logic [7:0] C_CONF  = 8'hD0;
  localparam logic [7:0] C_CLR   = 8'h50;
  localparam logic [7:0] C_ARR   = 8'hFF;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ERASE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          rd_stat, fail_q;
  logic          f_vpp, f_seq, f_ers;
  logic          rd_act, rd_act_q;
  logic [7:0]    status;

  assign busy   = (st == S_ERASE);
  assign status = {~busy, 1'b0, f_ers, f_seq, f_vpp, 3'b000};
  assign rd_act = ~ce_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      rd_stat   <= 1'b0;
      fail_q    <= 1'b0;
      f_vpp     <= 1'b0;
      f_seq     <= 1'b0;
      f_ers     <= 1'b0;
      erase_blk <= '0;
    end else begin
      case (st)
        S_IDLE: if (wr_en) begin
          case (wr_data)
            C_SETUP: begin st <= S_SETUP; rd_stat <= 1'b1; end
            C_CLR:   begin f_vpp <= 1'b0; f_seq <= 1'b0; f_ers <= 1'b0; end
            C_ARR:   rd_stat <= 1'b0;
            default: ;
          endcase
        end
        S_SETUP: if (wr_en) begin
          rd_stat <= 1'b1;
          if (wr_data == C_CONF) begin
            if (vpp_low) begin
              f_vpp <= 1'b1;
              f_ers <= 1'b1;
              st    <= S_IDLE;
            end else begin
              st        <= S_ERASE;
              cnt       <= CW'(ERASE_CYCLES - 1);
              fail_q    <= force_fail;
              erase_blk <= wr_addr[ADDR_W-1 -: BLK_W];
            end
          end else begin
            f_seq <= 1'b1;
            f_ers <= 1'b1;
            st    <= S_IDLE;
          end
        end
        S_ERASE: begin
          if (cnt == '0) begin
            st <= S_IDLE;
            if (fail_q) f_ers <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_act_q <= rd_act;
      if (rd_act && !rd_act_q)
        rd_data <= rd_stat ? status : ARRAY_FILL;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !rd_stat); // R1
  AST_SETUP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && wr_en && wr_data == C_SETUP) |=> rd_stat && st == S_SETUP); // R2
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_data == C_CONF && !vpp_low)); // R3
  AST_BLK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(erase_blk)); // R4
  AST_SEQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP && wr_en && wr_data != C_CONF) |=> f_seq && f_ers && !busy); // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && wr_en && wr_data == C_CLR) |=> !f_vpp && !f_seq && !f_ers); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (f_ers && !(st == S_IDLE && wr_en && wr_data == C_CLR)) |=> f_ers); // R7
  AST_VPP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP && wr_en && wr_data == C_CONF && vpp_low) |=> !busy && f_vpp); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rd_act_q) |=> $stable(rd_data)); // R9
  AST_BUSY_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rd_stat); // R10

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int EC = 12;
  localparam logic [7:0] FILL = 8'hA5;

  logic clk = 0, rst_n = 0, wr_en = 0, ce_n = 1, oe_n = 1, vpp_low = 0, force_fail = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] wr_addr = 0;
  logic [7:0]  rd_data;
  logic        busy;
  logic [3:0]  erase_blk;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       smp;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ERASE_CYCLES(EC), .ADDR_W(16), .BLK_W(4), .ARRAY_FILL(FILL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_addr(wr_addr),
    .ce_n(ce_n), .oe_n(oe_n), .vpp_low(vpp_low), .force_fail(force_fail),
    .rd_data(rd_data), .busy(busy), .erase_blk(erase_blk));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always begin
    @(smp);
    while (exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic wr(logic [7:0] d, logic [15:0] a = 16'h0);
    @(negedge clk); wr_en = 1; wr_data = d; wr_addr = a;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic open_rd();
    @(negedge clk); ce_n = 0; oe_n = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic close_rd();
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic rd(logic [7:0] exp, string tag);
    open_rd();
    exp_q.push_back(exp); tag_q.push_back(tag);
    -> smp; #0;
    close_rd();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    #400000;
    n_fail++; n_run++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    rd(FILL, "R1 array mode after reset");

    wr(8'h20);
    rd(8'h80, "R2 status after setup");
    wr(8'hD0, 16'hB123);
    chk("R3 busy after confirm", busy, 1);
    rd(8'h00, "R3 status while busy");
    chk("R4 erase block", erase_blk, 4'hB);
    wait_idle(n);
    chk("R4 busy length", n + 4, EC);
    rd(8'h80, "R2 ready after erase");
    wr(8'hFF);
    rd(FILL, "R10 FFh selects array");

    wr(8'h20); wr(8'h40);
    chk("R5 no busy on bad confirm", busy, 0);
    rd(8'hB0, "R5 seq error bits");
    wr(8'h50);
    rd(8'h80, "R6 clear keeps bit7");

    force_fail = 1;
    wr(8'h20); wr(8'hD0, 16'h3000);
    force_fail = 0;
    wait_idle(n);
    rd(8'hA0, "R7 forced failure");
    wr(8'h20); wr(8'hD0, 16'h4000);
    wait_idle(n);
    rd(8'hA0, "R7 error sticky");
    wr(8'h50);
    rd(8'h80, "R7 cleared by 50h");

    vpp_low = 1;
    wr(8'h20); wr(8'hD0, 16'h5000);
    chk("R8 no busy on low vpp", busy, 0);
    vpp_low = 0;
    rd(8'hA8, "R8 vpp bits");
    chk("R8 block unchanged", erase_blk, 4'h4);
    wr(8'h50);

    open_rd();
    exp_q.push_back(8'h80); tag_q.push_back("R9 first capture"); -> smp; #0;
    wr(8'h20); wr(8'hD0, 16'h6000);
    @(negedge clk);
    exp_q.push_back(8'h80); tag_q.push_back("R9 held while open"); -> smp; #0;
    close_rd();
    rd(8'h00, "R9 refreshed on new enable");

    wr(8'hFF);
    wr(8'h50);
    wait_idle(n);
    rd(8'h80, "R10 FFh ignored while busy");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule